// File: doc/BRIEF.md
# Bus Cycle and I/O Select Decoder

This block sits on a system board next to the processor. It watches the address strobe and, in the clock where the strobe is low, captures the three cycle-definition outputs: memory-or-I/O, data-or-code, and write-or-read. It also captures the byte enables and the low I/O address. From these it classifies the cycle and holds that classification until the cycle's ready is returned.

For I/O cycles that fall in the lowest 256-byte port range, the block drives one of eight legacy peripheral group selects. It also drives an I/O read or I/O write strobe, and both stay asserted until the cycle's ready. For special cycles it tells halt from shutdown using the byte-enable pattern. A shutdown also raises a soft-reset (INIT) request to the processor for a fixed number of clocks. All pins are plain control signals. There is no streaming data path, so there is no valid/ready back-pressure to honour.

Top module: `cycdec_top`

## Requirements
- R1: After reset, `cyc_kind` is 0 (idle), `grp_sel` is 0, and `io_rd`, `io_wr`, `halt_cyc`, `shut_cyc` and `init_req` are all low.
- R2: Cycle-definition inputs, byte enables and `io_a` are sampled only at the clock edge where `ads_n` is low and no cycle is outstanding. Later changes to them do not affect the outputs of that cycle.
- R3: The cycle is classified from (mio, dc, wr) and reported on `cyc_kind` from the clock after the strobe until the ready edge. Codes: mio=1,wr=0,dc=1 gives 1 (memory read); mio=1,wr=1 gives 2 (memory write); mio=1,wr=0,dc=0 gives 3 (code fetch); mio=0,dc=1,wr=0 gives 4 (I/O read); mio=0,dc=1,wr=1 gives 5 (I/O write); mio=0,dc=0,wr=0 gives 6 (interrupt acknowledge); mio=0,dc=0,wr=1 gives 7 (special cycle).
- R4: On an I/O cycle, `io_a[2:0]` (port address bits 7:5) picks the group, and `grp_sel` is one-hot at that bit index. The groups in index order are: DMA 1, interrupt controller 1, timer, keyboard/digital I/O, DMA page, interrupt controller 2, DMA 2, FPU. For example, a write to port 43h selects bit 2.
- R5: Selects and strobes are asserted only when `io_a[10:3]` (port address bits 15:8) is zero. Otherwise the cycle is still classified, but `grp_sel`, `io_rd` and `io_wr` stay low.
- R6: `io_rd` is high for qualifying I/O reads and `io_wr` for qualifying I/O writes. Each is held through any number of wait states. Each falls, together with `grp_sel` and `cyc_kind`, in the clock after `brdy_n` is sampled low.
- R7: During a special cycle, `halt_cyc` is high when the latched `be_n` is 8'hFD (lane 1 low). `shut_cyc` is high when it is 8'hFE (lane 0 low). Any other pattern raises neither.
- R8: A shutdown special cycle raises `init_req` for exactly INIT_CYC clocks, starting in the clock after the strobe.
- R9: A strobe while a cycle is outstanding is ignored. A ready while no cycle is outstanding is ignored.
- R10: Memory, code, interrupt-acknowledge and special cycles never assert `grp_sel`, `io_rd` or `io_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ads_n | input | 1 | Address strobe, active low |
| mio | input | 1 | 1 = memory cycle, 0 = I/O |
| dc | input | 1 | 1 = data, 0 = code/control |
| wr | input | 1 | 1 = write, 0 = read |
| io_a | input | 11 | Port address bits 15:5 |
| be_n | input | 8 | Byte enables, active low |
| brdy_n | input | 1 | Cycle ready, active low |
| cyc_kind | output | 3 | Cycle class code (R3), 0 when idle |
| grp_sel | output | 8 | One-hot peripheral group select |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| halt_cyc | output | 1 | Halt special cycle in progress |
| shut_cyc | output | 1 | Shutdown special cycle in progress |
| init_req | output | 1 | Soft-reset request pulse |

## Verification
Every output comes from a single register stage. Classification, selects, strobes and special-cycle flags therefore become valid one edge after the edge that sees the strobe low. They drop one edge after the edge that sees ready low. The INIT request rises on the same edge as the classification and stays high for INIT_CYC edges. The bench drives inputs on falling edges and samples on the next falling edge, so each check lands in the first cycle a result is due. Right after the strobe edge it scrambles the cycle-definition inputs, and it holds ready high for a counted number of falling edges to test that outputs are held through wait states.

// File: rtl/cycdec_pkg.sv
package cycdec_pkg;
  typedef enum logic [2:0] {
    CK_IDLE  = 3'd0,
    CK_MEMRD = 3'd1,
    CK_MEMWR = 3'd2,
    CK_CODE  = 3'd3,
    CK_IORD  = 3'd4,
    CK_IOWR  = 3'd5,
    CK_INTA  = 3'd6,
    CK_SPEC  = 3'd7
  } cyc_kind_e;

  localparam logic [7:0] HALT_BE = 8'hFD;
  localparam logic [7:0] SHUT_BE = 8'hFE;

  function automatic cyc_kind_e classify(input logic m, input logic d, input logic w);
    cyc_kind_e k;
    if (m) begin
      if (w)      k = CK_MEMWR;
      else if (d) k = CK_MEMRD;
      else        k = CK_CODE;
    end else if (d) begin
      k = w ? CK_IOWR : CK_IORD;
    end else begin
      k = w ? CK_SPEC : CK_INTA;
    end
    return k;
  endfunction
endpackage

// File: rtl/cycdec_capture.sv
module cycdec_capture
  import cycdec_pkg::*;
#(
  parameter int IOA_W = 11,
  parameter int BE_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ads_n,
  input  logic             brdy_n,
  input  logic             mio,
  input  logic             dc,
  input  logic             wr,
  input  logic [IOA_W-1:0] io_a,
  input  logic [BE_W-1:0]  be_n,
  output logic             take,
  output cyc_kind_e        kind_q,
  output logic [IOA_W-1:0] ioa_q,
  output logic [BE_W-1:0]  be_q
);
  logic busy;
  assign busy = (kind_q != CK_IDLE);
  assign take = !ads_n && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= CK_IDLE;
      ioa_q  <= '0;
      be_q   <= '1;
    end else if (take) begin
      kind_q <= classify(mio, dc, wr);
      ioa_q  <= io_a;
      be_q   <= be_n;
    end else if (busy && !brdy_n) begin
      kind_q <= CK_IDLE;
    end
  end
endmodule

// File: rtl/cycdec_iosel.sv
module cycdec_iosel
  import cycdec_pkg::*;
#(
  parameter int IOA_W = 11,
  parameter int GRP_W = 3
) (
  input  cyc_kind_e             kind_q,
  input  logic [IOA_W-1:0]      ioa_q,
  output logic [(1<<GRP_W)-1:0] grp_sel,
  output logic                  io_rd,
  output logic                  io_wr
);
  localparam int N_GRP = 1 << GRP_W;

  logic is_io, low_page;
  logic [GRP_W-1:0] grp;

  assign is_io    = (kind_q == CK_IORD) || (kind_q == CK_IOWR);
  assign low_page = (ioa_q[IOA_W-1:GRP_W] == '0);
  assign grp      = ioa_q[GRP_W-1:0];
  assign io_rd    = low_page && (kind_q == CK_IORD);
  assign io_wr    = low_page && (kind_q == CK_IOWR);

  for (genvar g = 0; g < N_GRP; g++) begin : g_sel
    assign grp_sel[g] = is_io && low_page && (grp == GRP_W'(g));
  end
endmodule

// File: rtl/cycdec_initgen.sv
module cycdec_initgen
  import cycdec_pkg::*;
#(
  parameter int INIT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic init_req
);
  localparam int CW = $clog2(INIT_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (fire)       cnt <= CW'(INIT_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign init_req = (cnt != '0);
endmodule

// File: rtl/cycdec_top.sv
module cycdec_top
  import cycdec_pkg::*;
#(
  parameter int IOA_W    = 11,
  parameter int BE_W     = 8,
  parameter int GRP_W    = 3,
  parameter int INIT_CYC = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ads_n,
  input  logic                  mio,
  input  logic                  dc,
  input  logic                  wr,
  input  logic [IOA_W-1:0]      io_a,
  input  logic [BE_W-1:0]       be_n,
  input  logic                  brdy_n,
  output logic [2:0]            cyc_kind,
  output logic [(1<<GRP_W)-1:0] grp_sel,
  output logic                  io_rd,
  output logic                  io_wr,
  output logic                  halt_cyc,
  output logic                  shut_cyc,
  output logic                  init_req
);
  cyc_kind_e        kind_q;
  logic [IOA_W-1:0] ioa_q;
  logic [BE_W-1:0]  be_q;
  logic             take, fire;

  cycdec_capture #(.IOA_W(IOA_W), .BE_W(BE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .brdy_n(brdy_n),
    .mio(mio), .dc(dc), .wr(wr), .io_a(io_a), .be_n(be_n),
    .take(take), .kind_q(kind_q), .ioa_q(ioa_q), .be_q(be_q)
  );

  cycdec_iosel #(.IOA_W(IOA_W), .GRP_W(GRP_W)) u_sel (
    .kind_q(kind_q), .ioa_q(ioa_q),
    .grp_sel(grp_sel), .io_rd(io_rd), .io_wr(io_wr)
  );

  // shutdown recognised straight from the strobe-edge inputs so INIT rises with the class
  assign fire = take && (classify(mio, dc, wr) == CK_SPEC) && (be_n == BE_W'(SHUT_BE));

  cycdec_initgen #(.INIT_CYC(INIT_CYC)) u_init (
    .clk(clk), .rst_n(rst_n), .fire(fire), .init_req(init_req)
  );

  assign cyc_kind = kind_q;
  assign halt_cyc = (kind_q == CK_SPEC) && (be_q == BE_W'(HALT_BE));
  assign shut_cyc = (kind_q == CK_SPEC) && (be_q == BE_W'(SHUT_BE));
endmodule

// File: rtl/cycdec_chk.sv
module cycdec_chk #(
  parameter int INIT_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ads_n,
  input logic       mio,
  input logic       dc,
  input logic       wr,
  input logic [7:0] be_n,
  input logic       brdy_n,
  input logic [2:0] cyc_kind,
  input logic [7:0] grp_sel,
  input logic       io_rd,
  input logic       io_wr,
  input logic       halt_cyc,
  input logic       shut_cyc,
  input logic       init_req
);
  logic [15:0] init_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        init_run <= '0;
    else if (init_req) init_run <= init_run + 1'b1;
    else               init_run <= '0;
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 3'd0 && !ads_n) |=> (cyc_kind != 3'd0));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind != 3'd0 && brdy_n) |=> $stable(cyc_kind));
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind != 3'd0 && !brdy_n) |=> (cyc_kind == 3'd0 && grp_sel == 8'd0 && !io_rd && !io_wr));
  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grp_sel));
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n) !(io_rd && io_wr));
  p_sel_io_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_sel != 8'd0) |-> (io_rd || io_wr));
  p_flags_r7: assert property (@(posedge clk) disable iff (!rst_n) !(halt_cyc && shut_cyc));
  p_init_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 3'd0 && !ads_n && !mio && !dc && wr && be_n == 8'hFE) |=> (init_req && shut_cyc));
  p_init_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_run <= 16'(INIT_CYC));
endmodule

bind cycdec_top cycdec_chk #(.INIT_CYC(INIT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .mio(mio), .dc(dc), .wr(wr),
  .be_n(be_n), .brdy_n(brdy_n), .cyc_kind(cyc_kind), .grp_sel(grp_sel),
  .io_rd(io_rd), .io_wr(io_wr), .halt_cyc(halt_cyc), .shut_cyc(shut_cyc),
  .init_req(init_req)
);

// File: tb/sim_cycdec_top.sv
`timescale 1ns/100ps
module sim_cycdec_top;
  localparam int INIT_CYC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ads_n = 1'b1, mio = 1'b0, dc = 1'b0, wr = 1'b0, brdy_n = 1'b1;
  logic [10:0] io_a = '0;
  logic [7:0]  be_n = 8'hFF;
  logic [2:0]  cyc_kind;
  logic [7:0]  grp_sel;
  logic io_rd, io_wr, halt_cyc, shut_cyc, init_req;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cycdec_top #(.INIT_CYC(INIT_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .mio(mio), .dc(dc), .wr(wr),
    .io_a(io_a), .be_n(be_n), .brdy_n(brdy_n), .cyc_kind(cyc_kind),
    .grp_sel(grp_sel), .io_rd(io_rd), .io_wr(io_wr), .halt_cyc(halt_cyc),
    .shut_cyc(shut_cyc), .init_req(init_req)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // independent expectation from the R3 code table
  function automatic logic [2:0] want_kind(logic m, logic d, logic w);
    if (m) return w ? 3'd2 : (d ? 3'd1 : 3'd3);
    if (d) return w ? 3'd5 : 3'd4;
    return w ? 3'd7 : 3'd6;
  endfunction

  // ends at the falling edge after the strobe edge; inputs scrambled afterwards (R2)
  task automatic start_cyc(logic m, logic d, logic w, logic [15:0] port, logic [7:0] be);
    @(negedge clk);
    ads_n = 1'b0; mio = m; dc = d; wr = w; io_a = port[15:5]; be_n = be;
    @(negedge clk);
    ads_n = 1'b1; mio = ~m; dc = ~d; wr = ~w; io_a = ~port[15:5]; be_n = ~be;
  endtask

  task automatic finish_cyc();
    brdy_n = 1'b0;
    @(negedge clk);
    brdy_n = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 kind", cyc_kind, 0);
    check("R1 sel", grp_sel, 0);
    check("R1 strobes", {io_rd, io_wr, halt_cyc, shut_cyc, init_req}, 0);
  endtask

  task automatic t_nonio();
    logic [2:0] mdw [4] = '{3'b101, 3'b111, 3'b100, 3'b000};
    foreach (mdw[i]) begin
      start_cyc(mdw[i][2], mdw[i][1], mdw[i][0], 16'h0043, 8'hF7);
      check("R3 kind", cyc_kind, want_kind(mdw[i][2], mdw[i][1], mdw[i][0]));
      check("R10 no select", {grp_sel, io_rd, io_wr}, 0);
      finish_cyc();
      check("R6 idle after ready", cyc_kind, 0);
    end
  endtask

  task automatic t_groups();
    for (int g = 0; g < 8; g++) begin
      logic w = g[0];
      start_cyc(1'b0, 1'b1, w, 16'(g * 32 + 3), 8'hF7);
      check("R3 io kind", cyc_kind, w ? 5 : 4);
      check("R4 group", grp_sel, 32'(1) << g);
      check("R6 strobes", {io_rd, io_wr}, w ? 2'b01 : 2'b10);
      finish_cyc();
      check("R6 release", {grp_sel, io_rd, io_wr}, 0);
    end
    start_cyc(1'b0, 1'b1, 1'b1, 16'h0043, 8'hF7);
    check("R4 port 43h timer", {grp_sel, io_wr}, {8'h04, 1'b1});
    finish_cyc();
  endtask

  task automatic t_high_port();
    start_cyc(1'b0, 1'b1, 1'b1, 16'h0143, 8'hF7);
    check("R5 kind still io", cyc_kind, 5);
    check("R5 no select", {grp_sel, io_rd, io_wr}, 0);
    finish_cyc();
    start_cyc(1'b0, 1'b1, 1'b0, 16'h8060, 8'hFE);
    check("R5 high read", {grp_sel, io_rd, io_wr}, 0);
    finish_cyc();
  endtask

  task automatic t_wait_hold();
    start_cyc(1'b0, 1'b1, 1'b0, 16'h00A1, 8'hFD);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R6 held read", {grp_sel, io_rd, io_wr}, {8'h20, 2'b10});
      check("R2 latched kind", cyc_kind, 4);
    end
    finish_cyc();
    check("R6 drop", {grp_sel, io_rd}, 0);
  endtask

  task automatic t_special();
    start_cyc(1'b0, 1'b0, 1'b1, 16'h0000, 8'hFD);
    check("R7 halt", {halt_cyc, shut_cyc, init_req}, 3'b100);
    check("R10 special no sel", {grp_sel, io_rd, io_wr}, 0);
    finish_cyc();
    start_cyc(1'b0, 1'b0, 1'b1, 16'h0000, 8'hFB);
    check("R7 other pattern", {halt_cyc, shut_cyc, init_req}, 0);
    finish_cyc();
    start_cyc(1'b0, 1'b0, 1'b1, 16'h0000, 8'hFE);
    check("R7 shutdown", {halt_cyc, shut_cyc}, 2'b01);
    check("R8 init first clock", init_req, 1);
    for (int k = 1; k < INIT_CYC; k++) begin
      @(negedge clk);
      check("R8 init held", init_req, 1);
    end
    @(negedge clk);
    check("R8 init ends", init_req, 0);
    finish_cyc();
    check("R6 special released", {cyc_kind, shut_cyc}, 0);
  endtask

  task automatic t_ignored();
    start_cyc(1'b0, 1'b1, 1'b1, 16'h0061, 8'hFF);
    ads_n = 1'b0; mio = 1'b0; dc = 1'b0; wr = 1'b1; be_n = 8'hFE; io_a = 11'h000;
    @(negedge clk);
    ads_n = 1'b1;
    @(negedge clk);
    check("R9 second strobe ignored", cyc_kind, 5);
    check("R9 no init from ignored", init_req, 0);
    check("R9 select kept", grp_sel, 8'h08);
    finish_cyc();
    check("R9 idle after ready", cyc_kind, 0);
    brdy_n = 1'b0;
    @(negedge clk);
    brdy_n = 1'b1;
    @(negedge clk);
    check("R9 stray ready", {cyc_kind, grp_sel, io_rd, io_wr}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nonio();
    t_groups();
    t_high_port();
    t_wait_hold();
    t_special();
    t_ignored();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule